// File: doc/BRIEF.md
# Converter Operating Mode Sequencer

This block is the control state machine of a delta-sigma converter. A register write delivers a 3-bit mode code together with a channel number. The sequencer then runs the matching operating sequence: free-running conversion, a one-shot conversion that falls back to power-down, idle, power-down, or one of four calibrations. It gates the internal clock and the modulator clock, and it holds or releases the filter/modulator reset. It keeps an active-low ready flag and a data register for conversion results. It also keeps an offset coefficient and a full-scale coefficient for each channel.

The modulator and filter are reduced to a sample-valid strobe and a sample word. Calibration results arrive on a separate coefficient word. Clock wake-up, filter settling and the output data period are all counted in system clock cycles, each set by its own parameter. A sequence completes on the first valid sample after its wait has run out.

Each mode has its own start state and end state. Continuous mode settles once and then produces results at the output data rate. Single mode wakes the clock, converts once and powers down. A calibration stores one coefficient and parks in idle. A new mode write restarts sequencing at once from the start state of the new mode.

States and transitions: reset enters ST_CONT_SETTLE. From any state, a mode write goes to ST_CONT_SETTLE (000), ST_SGL_WAKE (001), ST_IDLE (010), ST_PDOWN (011) or ST_CAL (1xx). ST_CONT_SETTLE goes to ST_CONT_RUN on its first result, and ST_CONT_RUN stays in ST_CONT_RUN on each later result. ST_SGL_WAKE goes to ST_SGL_CONV when the wake-up count runs out. ST_SGL_CONV goes to ST_PDOWN on its result. ST_CAL goes to ST_IDLE when the coefficient is stored. ST_IDLE and ST_PDOWN leave only on a mode write.

Top module: `conv_mode_seq`

## Requirements
- R1: After reset the block is in continuous mode (code 000): rdy_n=1, filt_rst=0, clk_en=1 and mod_clk_en=1. Every offset and full-scale coefficient reads 0.
- R2: In continuous mode the first result is captured SETTLE_CYC cycles after entry (reset release, or the edge that samples a 000 write). Capture requires smp_valid=1 at that edge; otherwise it waits for the first edge with smp_valid=1. Capture loads data_out from smp_data and drives rdy_n low. Later results follow every ODR_CYC cycles.
- R3: In continuous mode with cont_read=1, a rd_strobe sets rdy_n high one cycle later. With cont_read=0, rd_strobe has no effect and rdy_n stays low.
- R4: Mode 001 first spends PWRUP_CYC cycles with clk_en=1, mod_clk_en=0 and filt_rst=1. It then converts for SETTLE_CYC cycles with filt_rst=0 and mod_clk_en=1. It then stores the sample, drives rdy_n low and enters power-down.
- R5: After a single conversion, rdy_n stays low and data_out keeps its value while power-down lasts. A rd_strobe sets rdy_n high whatever the value of cont_read.
- R6: In idle (010): filt_rst=1, mod_clk_en=1 and clk_en=1.
- R7: In power-down (011): clk_en=0, mod_clk_en=0 and filt_rst=1. In every mode, bridge_sw follows bridge_req and xtal_en follows xtal_sel one cycle later.
- R8: A calibration (codes 100 to 111) runs SETTLE_CYC cycles with the filter released and rdy_n high. It ends on a valid sample, then drives rdy_n low and enters idle.
- R9: A calibration with mode bit 0 = 0 writes cal_word into the offset coefficient of the channel latched at the write. With bit 0 = 1 it writes the full-scale coefficient of that channel. No other coefficient changes. coef_ch selects the channel read on ofs_out and fs_out.
- R10: Every mode write sets rdy_n high and restarts at the new mode's start state, aborting any running sequence. A write on the same edge as a completion wins, and no result or coefficient is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode code for the write |
| chan_sel | input | CHW | Channel latched with a mode write |
| cont_read | input | 1 | Continuous-read enable |
| rd_strobe | input | 1 | Result has been read |
| smp_valid | input | 1 | Filter sample valid |
| smp_data | input | DW | Filter sample word |
| cal_word | input | DW | Calibration coefficient to store |
| coef_ch | input | CHW | Coefficient readback channel |
| bridge_req | input | 1 | Requested bridge switch state |
| xtal_sel | input | 1 | External crystal selected |
| rdy_n | output | 1 | Active-low ready flag |
| data_out | output | DW | Data register |
| filt_rst | output | 1 | Filter and modulator held in reset |
| clk_en | output | 1 | Internal clock powered |
| mod_clk_en | output | 1 | Modulator clock running |
| ofs_out | output | DW | Offset coefficient of coef_ch |
| fs_out | output | DW | Full-scale coefficient of coef_ch |
| bridge_sw | output | 1 | Bridge power switch drive |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The bench builds the block with DW=16, NCH=4, SETTLE_CYC=6, ODR_CYC=3 and PWRUP_CYC=5. With these values every wake-up, settling and rate boundary lies a few cycles from its start, so the bench can sample each side of a boundary. Four channels make a wrong channel decode visible. The short settling window also makes it easy to land a mode write on the exact edge where a calibration would complete.

// File: rtl/conv_mode_pkg.sv
package conv_mode_pkg;

    typedef enum logic [2:0] {
        M_CONT   = 3'd0,
        M_SINGLE = 3'd1,
        M_IDLE   = 3'd2,
        M_PDOWN  = 3'd3,
        M_ZS_INT = 3'd4,
        M_FS_INT = 3'd5,
        M_ZS_SYS = 3'd6,
        M_FS_SYS = 3'd7
    } op_mode_e;

    typedef enum logic [2:0] {
        ST_CONT_SETTLE,
        ST_CONT_RUN,
        ST_SGL_WAKE,
        ST_SGL_CONV,
        ST_PDOWN,
        ST_IDLE,
        ST_CAL
    } seq_state_e;

endpackage

// File: rtl/conv_wait_timer.sv
module conv_wait_timer #(
    parameter int TW      = 8,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= TW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_busy,
    input  logic          finish,
    input  logic          load_data,
    input  logic [DW-1:0] new_data,
    input  logic          rd_clr,
    output logic          rdy_n,
    output logic [DW-1:0] data_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_n  <= 1'b1;
            data_q <= '0;
        end else begin
            if (load_data) begin
                data_q <= new_data;
            end
            if (set_busy) begin
                rdy_n <= 1'b1;
            end else if (finish) begin
                rdy_n <= 1'b0;
            end else if (rd_clr) begin
                rdy_n <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/conv_coef_bank.sv
module conv_coef_bank #(
    parameter int DW  = 24,
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic           wr_fs,
    input  logic [CHW-1:0] wr_ch,
    input  logic [DW-1:0]  wr_data,
    input  logic [CHW-1:0] rd_ch,
    output logic [DW-1:0]  ofs_rd,
    output logic [DW-1:0]  fs_rd
);

    logic [NCH*DW-1:0] ofs_flat;
    logic [NCH*DW-1:0] fs_flat;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DW-1:0] ofs_r;
        logic [DW-1:0] fs_r;
        logic          hit;

        assign hit = wr && (wr_ch == CHW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ofs_r <= '0;
                fs_r  <= '0;
            end else if (hit) begin
                if (wr_fs) begin
                    fs_r <= wr_data;
                end else begin
                    ofs_r <= wr_data;
                end
            end
        end

        assign ofs_flat[g*DW +: DW] = ofs_r;
        assign fs_flat[g*DW +: DW]  = fs_r;
    end

    assign ofs_rd = ofs_flat[rd_ch*DW +: DW];
    assign fs_rd  = fs_flat[rd_ch*DW +: DW];

endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
    import conv_mode_pkg::*;
#(
    parameter int DW         = 24,
    parameter int NCH        = 2,
    parameter int SETTLE_CYC = 4800,
    parameter int ODR_CYC    = 1200,
    parameter int PWRUP_CYC  = 4915,
    localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_wr,
    input  logic [2:0]     mode_in,
    input  logic [CHW-1:0] chan_sel,
    input  logic           cont_read,
    input  logic           rd_strobe,
    input  logic           smp_valid,
    input  logic [DW-1:0]  smp_data,
    input  logic [DW-1:0]  cal_word,
    input  logic [CHW-1:0] coef_ch,
    input  logic           bridge_req,
    input  logic           xtal_sel,
    output logic           rdy_n,
    output logic [DW-1:0]  data_out,
    output logic           filt_rst,
    output logic           clk_en,
    output logic           mod_clk_en,
    output logic [DW-1:0]  ofs_out,
    output logic [DW-1:0]  fs_out,
    output logic           bridge_sw,
    output logic           xtal_en
);

    localparam int MAX_AB = (SETTLE_CYC > ODR_CYC) ? SETTLE_CYC : ODR_CYC;
    localparam int MAX_C  = (MAX_AB > PWRUP_CYC) ? MAX_AB : PWRUP_CYC;
    localparam int TW     = $clog2(MAX_C + 1);
    localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] ODR_V    = TW'(ODR_CYC - 1);
    localparam logic [TW-1:0] PWRUP_V  = TW'(PWRUP_CYC - 1);

    seq_state_e     state, nxt_state;
    logic [CHW-1:0] ch_q;
    logic           fs_q;
    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_done;
    logic           smp_hit;
    logic           capture;
    logic           cal_wr;
    logic           in_cont;
    logic           rd_clr;

    assign smp_hit = tmr_done && smp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CONT_SETTLE;
            ch_q  <= '0;
            fs_q  <= 1'b0;
        end else begin
            state <= nxt_state;
            if (mode_wr) begin
                ch_q <= chan_sel;
                fs_q <= mode_in[0];
            end
        end
    end

    // next state and sequencing strobes
    always_comb begin
        nxt_state = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        capture   = 1'b0;
        cal_wr    = 1'b0;
        if (mode_wr) begin
            tmr_load = 1'b1;
            unique case (op_mode_e'(mode_in))
                M_CONT: begin
                    nxt_state = ST_CONT_SETTLE;
                    tmr_val   = SETTLE_V;
                end
                M_SINGLE: begin
                    nxt_state = ST_SGL_WAKE;
                    tmr_val   = PWRUP_V;
                end
                M_IDLE:  nxt_state = ST_IDLE;
                M_PDOWN: nxt_state = ST_PDOWN;
                default: begin
                    nxt_state = ST_CAL;
                    tmr_val   = SETTLE_V;
                end
            endcase
        end else begin
            unique case (state)
                ST_CONT_SETTLE, ST_CONT_RUN: begin
                    if (smp_hit) begin
                        capture   = 1'b1;
                        nxt_state = ST_CONT_RUN;
                        tmr_load  = 1'b1;
                        tmr_val   = ODR_V;
                    end
                end
                ST_SGL_WAKE: begin
                    if (tmr_done) begin
                        nxt_state = ST_SGL_CONV;
                        tmr_load  = 1'b1;
                        tmr_val   = SETTLE_V;
                    end
                end
                ST_SGL_CONV: begin
                    if (smp_hit) begin
                        capture   = 1'b1;
                        nxt_state = ST_PDOWN;
                    end
                end
                ST_CAL: begin
                    if (smp_hit) begin
                        cal_wr    = 1'b1;
                        nxt_state = ST_IDLE;
                    end
                end
                ST_IDLE, ST_PDOWN: ;
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        filt_rst   = 1'b1;
        clk_en     = 1'b1;
        mod_clk_en = 1'b1;
        unique case (state)
            ST_CONT_SETTLE, ST_CONT_RUN, ST_SGL_CONV, ST_CAL: filt_rst = 1'b0;
            ST_SGL_WAKE: mod_clk_en = 1'b0;
            ST_PDOWN: begin
                clk_en     = 1'b0;
                mod_clk_en = 1'b0;
            end
            ST_IDLE: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bridge_sw <= 1'b0;
            xtal_en   <= 1'b0;
        end else begin
            bridge_sw <= bridge_req;
            xtal_en   <= xtal_sel;
        end
    end

    assign in_cont = (state == ST_CONT_SETTLE) || (state == ST_CONT_RUN);
    assign rd_clr  = rd_strobe && (cont_read || !in_cont);

    conv_wait_timer #(
        .TW      (TW),
        .RST_VAL (SETTLE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    conv_result_reg #(
        .DW (DW)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_busy  (mode_wr),
        .finish    (capture || cal_wr),
        .load_data (capture),
        .new_data  (smp_data),
        .rd_clr    (rd_clr),
        .rdy_n     (rdy_n),
        .data_q    (data_out)
    );

    conv_coef_bank #(
        .DW  (DW),
        .NCH (NCH),
        .CHW (CHW)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cal_wr),
        .wr_fs   (fs_q),
        .wr_ch   (ch_q),
        .wr_data (cal_word),
        .rd_ch   (coef_ch),
        .ofs_rd  (ofs_out),
        .fs_rd   (fs_out)
    );

endmodule

// File: rtl/conv_mode_seq_chk.sv
module conv_mode_seq_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_wr,
    input logic          smp_valid,
    input logic          rdy_n,
    input logic          filt_rst,
    input logic          clk_en,
    input logic          mod_clk_en,
    input logic [DW-1:0] data_out
);

    AST_RDY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(smp_valid)); // R2

    AST_WAKE_FILT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !mod_clk_en) |-> filt_rst); // R4

    AST_PDOWN_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && $past(!clk_en)) |-> $stable(data_out)); // R5

    AST_PDOWN_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!mod_clk_en && filt_rst)); // R7

    AST_WRITE_RAISES_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> rdy_n); // R10

endmodule

bind conv_mode_seq conv_mode_seq_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .smp_valid  (smp_valid),
    .rdy_n      (rdy_n),
    .filt_rst   (filt_rst),
    .clk_en     (clk_en),
    .mod_clk_en (mod_clk_en),
    .data_out   (data_out)
);

// File: tb/sim_conv_mode_seq.sv
module sim_conv_mode_seq;

    localparam int CLK_PER = 10;
    localparam int DW      = 16;
    localparam int NCH     = 4;
    localparam int CHW     = 2;
    localparam int SETTLE  = 6;
    localparam int ODR     = 3;
    localparam int PWRUP   = 5;

    // {mode, wait, rdy_n, filt_rst, clk_en, mod_clk_en}
    localparam logic [14:0] VEC [11] = '{
        {3'd2, 8'd0,  4'b1111},
        {3'd3, 8'd0,  4'b1100},
        {3'd1, 8'd0,  4'b1110},
        {3'd1, 8'd5,  4'b1011},
        {3'd1, 8'd11, 4'b0100},
        {3'd1, 8'd10, 4'b1011},
        {3'd0, 8'd5,  4'b1011},
        {3'd0, 8'd6,  4'b0011},
        {3'd4, 8'd0,  4'b1011},
        {3'd4, 8'd6,  4'b0111},
        {3'd7, 8'd6,  4'b0111}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_wr = 1'b0;
    logic [2:0]     mode_in = '0;
    logic [CHW-1:0] chan_sel = '0;
    logic           cont_read = 1'b0;
    logic           rd_strobe = 1'b0;
    logic           smp_valid = 1'b1;
    logic [DW-1:0]  smp_data = '0;
    logic [DW-1:0]  cal_word = '0;
    logic [CHW-1:0] coef_ch = '0;
    logic           bridge_req = 1'b0;
    logic           xtal_sel = 1'b0;
    logic           rdy_n;
    logic [DW-1:0]  data_out;
    logic           filt_rst;
    logic           clk_en;
    logic           mod_clk_en;
    logic [DW-1:0]  ofs_out;
    logic [DW-1:0]  fs_out;
    logic           bridge_sw;
    logic           xtal_en;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    conv_mode_seq #(
        .DW(DW), .NCH(NCH), .SETTLE_CYC(SETTLE), .ODR_CYC(ODR), .PWRUP_CYC(PWRUP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .chan_sel(chan_sel), .cont_read(cont_read), .rd_strobe(rd_strobe),
        .smp_valid(smp_valid), .smp_data(smp_data), .cal_word(cal_word),
        .coef_ch(coef_ch), .bridge_req(bridge_req), .xtal_sel(xtal_sel),
        .rdy_n(rdy_n), .data_out(data_out), .filt_rst(filt_rst),
        .clk_en(clk_en), .mod_clk_en(mod_clk_en), .ofs_out(ofs_out),
        .fs_out(fs_out), .bridge_sw(bridge_sw), .xtal_en(xtal_en)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; returns at the negedge after the sampling edge
    task automatic write_mode(input logic [2:0] m, input logic [CHW-1:0] ch);
        mode_in  = m;
        chan_sel = ch;
        mode_wr  = 1'b1;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0:    return "R2 vector";
            3'd1:    return "R4 vector";
            3'd2:    return "R6 vector";
            3'd3:    return "R7 vector";
            default: return "R8 vector";
        endcase
    endfunction

    task automatic show_coef(input logic [CHW-1:0] ch);
        coef_ch = ch;
        #1;
    endtask

    initial begin
        #(CLK_PER * 20000);
        n_bad++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        wait_n(3);
        chk("R1 outputs", {28'd0, rdy_n, filt_rst, clk_en, mod_clk_en}, 32'hF & 4'b1011);
        show_coef(2'd3);
        chk("R1 coef", {ofs_out, fs_out}, 32'd0);

        // R2: first result after settling from reset release
        smp_data = 16'hA1A1;
        rst_n = 1'b1;
        wait_n(5);
        chk("R2 before settle", {31'd0, rdy_n}, 32'd1);
        wait_n(1);
        chk("R2 first result rdy", {31'd0, rdy_n}, 32'd0);
        chk("R2 first result data", {16'd0, data_out}, 32'hA1A1);
        // R3: strobe ignored without continuous read
        smp_data  = 16'hB2B2;
        rd_strobe = 1'b1;
        wait_n(1);
        rd_strobe = 1'b0;
        chk("R3 strobe ignored", {31'd0, rdy_n}, 32'd0);
        wait_n(1);
        chk("R2 rate hold", {16'd0, data_out}, 32'hA1A1);
        wait_n(1);
        chk("R2 rate update", {16'd0, data_out}, 32'hB2B2);
        // R3: continuous read strobe raises ready
        cont_read = 1'b1;
        rd_strobe = 1'b1;
        smp_data  = 16'hC3C3;
        wait_n(1);
        rd_strobe = 1'b0;
        chk("R3 strobe clears", {31'd0, rdy_n}, 32'd1);
        wait_n(2);
        chk("R3 next result", {15'd0, rdy_n, data_out}, 32'h0000C3C3);
        cont_read = 1'b0;

        // vector table
        for (int i = 0; i < 11; i++) begin
            write_mode(VEC[i][14:12], '0);
            wait_n(int'(VEC[i][11:4]));
            chk(tag_of(VEC[i][14:12]), {28'd0, rdy_n, filt_rst, clk_en, mod_clk_en},
                {28'd0, VEC[i][3:0]});
        end

        // R2: completion waits for a valid sample
        write_mode(3'd0, '0);
        smp_valid = 1'b0;
        smp_data  = 16'h5555;
        wait_n(8);
        chk("R2 no valid sample", {31'd0, rdy_n}, 32'd1);
        smp_valid = 1'b1;
        wait_n(1);
        chk("R2 late valid sample", {15'd0, rdy_n, data_out}, 32'h00005555);

        // R4 / R5: single conversion then hold in power-down
        smp_data = 16'hD4D4;
        write_mode(3'd1, '0);
        wait_n(PWRUP + SETTLE);
        chk("R4 single result", {15'd0, rdy_n, data_out}, 32'h0000D4D4);
        smp_data = 16'hE5E5;
        wait_n(4);
        chk("R5 hold in power-down", {15'd0, rdy_n, data_out}, 32'h0000D4D4);
        rd_strobe = 1'b1;
        wait_n(1);
        rd_strobe = 1'b0;
        chk("R5 strobe clears", {31'd0, rdy_n}, 32'd1);

        // R9: coefficient targets
        cal_word = 16'h1234;
        write_mode(3'd4, 2'd2);
        wait_n(SETTLE);
        show_coef(2'd2);
        chk("R9 int zero-scale ch2", {ofs_out, fs_out}, 32'h12340000);
        cal_word = 16'h5678;
        write_mode(3'd5, 2'd1);
        wait_n(SETTLE);
        show_coef(2'd1);
        chk("R9 int full-scale ch1", {ofs_out, fs_out}, 32'h00005678);
        show_coef(2'd2);
        chk("R9 ch2 untouched", {ofs_out, fs_out}, 32'h12340000);
        cal_word = 16'h9ABC;
        write_mode(3'd6, 2'd3);
        wait_n(SETTLE);
        show_coef(2'd3);
        chk("R9 sys zero-scale ch3", {ofs_out, fs_out}, 32'h9ABC0000);
        cal_word = 16'hDEF0;
        write_mode(3'd7, 2'd0);
        wait_n(SETTLE);
        show_coef(2'd0);
        chk("R9 sys full-scale ch0", {ofs_out, fs_out}, 32'h0000DEF0);

        // R10: write on the completion edge aborts the calibration
        cal_word = 16'hFFFF;
        write_mode(3'd4, 2'd2);
        wait_n(SETTLE - 1);
        write_mode(3'd2, 2'd0);
        show_coef(2'd2);
        chk("R10 abort no store", {16'd0, ofs_out}, 32'h1234);
        chk("R10 abort idle", {30'd0, rdy_n, filt_rst}, 32'd3);
        // R10: abort single, restart continuous from settling
        smp_data = 16'h7777;
        write_mode(3'd1, '0);
        wait_n(7);
        write_mode(3'd0, '0);
        wait_n(SETTLE - 1);
        chk("R10 restart settling", {31'd0, rdy_n}, 32'd1);
        wait_n(1);
        chk("R10 restart result", {15'd0, rdy_n, data_out}, 32'h00007777);

        // R7: bridge switch and crystal kept in power-down
        write_mode(3'd3, '0);
        bridge_req = 1'b1;
        xtal_sel   = 1'b1;
        wait_n(1);
        chk("R7 pd keeps bridge/xtal", {29'd0, bridge_sw, xtal_en, clk_en}, 32'd6);
        bridge_req = 1'b0;
        wait_n(1);
        chk("R7 bridge follows", {31'd0, bridge_sw}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule